// File: doc/BRIEF.md
# Maskable Event Interrupt and DMA Request Controller

This block sits beside a data-acquisition core and turns eight event conditions into two host-facing signals: an active-low interrupt line and an active-high DMA request line. Each event arrives as a one-cycle pulse and sets its own sticky status bit. A per-event enable mask decides which of the latched bits may pull the interrupt line low. The host reads the status register through a read strobe, and that read clears every pending bit.

The same configuration word that holds the enable mask also holds a FIFO threshold. The DMA request rises once the fill count of the result FIFO matches the threshold. It then stays high until the FIFO is empty, so a DMA engine can drain the FIFO in one burst. The FIFO and the event sources live outside the block.

Top module: `irq_dma_ctrl`

## Requirements
- R1: After a synchronous reset, all status bits are 0, the mask and threshold are 0, `irq_n` is 1 and `dma_req` is 0.
- R2: A pulse on `evt_pulse[i]` sets status bit i at the next clock edge, whatever the mask says. The bit then stays set until a status read clears it.
- R3: `irq_n` is 0 in any cycle where some status bit and its mask bit are both 1, one cycle after the edge that latched the later of the two.
- R4: A status bit whose mask bit is 0 has no effect on `irq_n`.
- R5: `stat_value` shows the status register. During a cycle with `stat_rd` high it shows the pending bits. The edge that ends that cycle clears every bit that has no event pulse in the same cycle.
- R6: An event pulse in the same cycle as `stat_rd` leaves its bit set after the read.
- R7: When `cfg_we` is 1, `cfg_wdata[7:0]` is loaded as the enable mask (1 = enabled) and `cfg_wdata[7+CNT_W:8]` as the FIFO threshold. Both take effect from the next cycle.
- R8: `dma_req` goes to 1 at the edge that samples `fifo_count` equal to a non-zero threshold. It then holds 1 while `fifo_count` stays non-zero.
- R9: `dma_req` goes to 0 at the edge that samples `fifo_count` equal to 0. This clear wins over the set, so a threshold of 0 never raises the request.
- R10: After a read that clears all enabled bits, with no new enabled event, `irq_n` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | N_EVT | One-cycle event pulses, one per condition |
| fifo_count | input | CNT_W | Current fill count of the result FIFO |
| stat_rd | input | 1 | Status read strobe; clears the status at the end of the cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | N_EVT+CNT_W | Configuration word: mask in the low bits, threshold above it |
| irq_n | output | 1 | Active-low interrupt |
| dma_req | output | 1 | Active-high DMA request |
| stat_value | output | N_EVT | Current status register |

## Verification
Every result in this block appears one edge after its cause. An event, read, configuration write or FIFO count is sampled at a rising edge. The status register and DMA flop change at that same edge, and `irq_n` follows from registered state with no further delay. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge. It compares all three outputs 2 ns after each rising edge. Its directed checks look one falling edge after the stimulus, so each check lands in the first cycle where the result is due.

// File: rtl/irq_dma_pkg.sv
// Shared definitions for the interrupt / DMA request controller.
// Assumes: nothing beyond standard SystemVerilog.
package irq_dma_pkg;

    // Default number of event conditions.
    localparam int unsigned EVT_COUNT_DEF = 8;
    // Default width of the FIFO fill count.
    localparam int unsigned FILL_W_DEF    = 5;

    // State of the DMA request flop.
    typedef enum logic {
        DMA_IDLE   = 1'b0,
        DMA_ACTIVE = 1'b1
    } dma_state_e;

endpackage

// File: rtl/irq_status_reg.sv
// Sticky interrupt status register. Each bit is set by its event pulse and
// cleared by a status read. A set in the same cycle as a read wins.
// Assumes: evt_i pulses are synchronous to clk; rd_i lasts one cycle per read.
module irq_status_reg #(
    parameter int unsigned N_EVT = irq_dma_pkg::EVT_COUNT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             rd_i,
    output logic [N_EVT-1:0] stat_o
);

    logic [N_EVT-1:0] stat_q;

    for (genvar g = 0; g < N_EVT; g++) begin : g_bit
        // Purpose: latch one event bit, clear on read unless re-set this cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[g] <= 1'b0;
            end else if (evt_i[g]) begin
                stat_q[g] <= 1'b1;
            end else if (rd_i) begin
                stat_q[g] <= 1'b0;
            end
        end
    end

    assign stat_o = stat_q;

    // R2: with no read, no bit that was set may drop.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6: a pulsed event is present after the edge, read or not.
    a_r6_evt_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R5: a read with no events leaves the register empty.
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && evt_i == '0) |=> (stat_q == '0));

endmodule

// File: rtl/irq_cfg_reg.sv
// Configuration register: the per-event enable mask plus the FIFO threshold,
// both loaded from one write word (mask in the low bits).
// Assumes: cfg_we_i is a single-cycle strobe.
module irq_cfg_reg #(
    parameter int unsigned N_EVT = irq_dma_pkg::EVT_COUNT_DEF,
    parameter int unsigned CNT_W = irq_dma_pkg::FILL_W_DEF,
    localparam int unsigned CFG_W = N_EVT + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [N_EVT-1:0] mask_o,
    output logic [CNT_W-1:0] thr_o
);

    logic [N_EVT-1:0] mask_q;
    logic [CNT_W-1:0] thr_q;

    // Purpose: load mask and threshold on a write; all disabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            thr_q  <= '0;
        end else if (cfg_we_i) begin
            mask_q <= cfg_wdata_i[N_EVT-1:0];
            thr_q  <= cfg_wdata_i[CFG_W-1:N_EVT];
        end
    end

    assign mask_o = mask_q;
    assign thr_o  = thr_q;

    // R7: a write is visible in the next cycle.
    a_r7_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (mask_q == $past(cfg_wdata_i[N_EVT-1:0]) &&
                      thr_q  == $past(cfg_wdata_i[CFG_W-1:N_EVT])));

endmodule

// File: rtl/dma_req_gen.sv
// DMA request set/reset flop. Set when the fill count equals the threshold,
// reset when the fill count is zero; reset has priority.
// Assumes: fifo count is synchronous to clk.
module dma_req_gen #(
    parameter int unsigned CNT_W = irq_dma_pkg::FILL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             req_o
);
    import irq_dma_pkg::*;

    dma_state_e state_q, state_d;
    logic       empty;
    logic       at_thr;

    assign empty  = (count_i == '0);
    assign at_thr = (count_i == thr_i);

    // Purpose: next state, empty clears ahead of threshold match.
    always_comb begin
        state_d = state_q;
        if (empty) begin
            state_d = DMA_IDLE;
        end else if (at_thr) begin
            state_d = DMA_ACTIVE;
        end
    end

    // Purpose: hold the request state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DMA_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_o = (state_q == DMA_ACTIVE);

    // R9: an empty FIFO always drops the request.
    a_r9_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == '0) |=> !req_o);

    // R8: a non-zero match raises the request.
    a_r8_thr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == thr_i && count_i != '0) |=> req_o);

    // R8: with the FIFO non-empty, an active request stays active.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && count_i != '0) |=> req_o);

endmodule

// File: rtl/irq_dma_ctrl.sv
// Top of the interrupt / DMA request controller. Combines the sticky status,
// the configuration register and the DMA flop, and gates the status with
// the mask to drive the active-low interrupt.
// Assumes: one clock domain, synchronous active-low reset.
module irq_dma_ctrl #(
    parameter int unsigned N_EVT = irq_dma_pkg::EVT_COUNT_DEF,
    parameter int unsigned CNT_W = irq_dma_pkg::FILL_W_DEF,
    localparam int unsigned CFG_W = N_EVT + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_pulse,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             stat_rd,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             irq_n,
    output logic             dma_req,
    output logic [N_EVT-1:0] stat_value
);

    logic [N_EVT-1:0] stat_w;
    logic [N_EVT-1:0] mask_w;
    logic [CNT_W-1:0] thr_w;
    logic [N_EVT-1:0] live_w;

    irq_status_reg #(.N_EVT(N_EVT)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_pulse),
        .rd_i   (stat_rd),
        .stat_o (stat_w)
    );

    irq_cfg_reg #(.N_EVT(N_EVT), .CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .mask_o      (mask_w),
        .thr_o       (thr_w)
    );

    dma_req_gen #(.CNT_W(CNT_W)) u_dma (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (fifo_count),
        .thr_i   (thr_w),
        .req_o   (dma_req)
    );

    // Purpose: per-event gating of latched status by its enable bit.
    for (genvar g = 0; g < N_EVT; g++) begin : g_gate
        assign live_w[g] = stat_w[g] & mask_w[g];
    end

    assign irq_n      = ~(|live_w);
    assign stat_value = stat_w;

    // R3: an enabled event (mask unchanged) drives the interrupt low next cycle.
    a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && |(evt_pulse & mask_w)) |=> !irq_n);

    // R10: a read with no events and no config change releases the interrupt.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt_pulse == '0 && !cfg_we) |=> irq_n);

    // R1: the cycle after reset is seen, both outputs are idle.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (irq_n && !dma_req && stat_value == '0));

endmodule

// File: tb/irq_dma_ctrl_tb_top.sv
// Self-checking bench: behavioural reference model compared every cycle,
// plus directed checks on each requirement.
module irq_dma_ctrl_tb_top;

    localparam int N_EVT = 8;
    localparam int CNT_W = 5;
    localparam int CFG_W = N_EVT + CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_EVT-1:0] evt_pulse = '0;
    logic [CNT_W-1:0] fifo_count = '0;
    logic             stat_rd = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             irq_n;
    logic             dma_req;
    logic [N_EVT-1:0] stat_value;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit started = 0;

    // Reference model state
    int m_stat = 0;
    int m_mask = 0;
    int m_thr = 0;
    int m_dma = 0;

    always #4 clk = ~clk;

    irq_dma_ctrl #(.N_EVT(N_EVT), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .fifo_count(fifo_count),
        .stat_rd(stat_rd), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .irq_n(irq_n), .dma_req(dma_req), .stat_value(stat_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at each edge, compare 2 ns later.
    always @(posedge clk) begin
        int cnt;
        cnt = int'(fifo_count);
        if (!rst_n) begin
            m_stat = 0; m_mask = 0; m_thr = 0; m_dma = 0;
        end else begin
            if (stat_rd) m_stat = 0;
            m_stat = m_stat | int'(evt_pulse);
            if (cnt == 0) m_dma = 0;
            else if (cnt == m_thr) m_dma = 1;
            if (cfg_we) begin
                m_mask = int'(cfg_wdata) % 256;
                m_thr  = int'(cfg_wdata) / 256;
            end
        end
        started = 1;
        #2;
        if (started && !done) begin
            check("R2", int'(stat_value), m_stat);
            check("R3", int'(irq_n), ((m_stat & m_mask) == 0) ? 1 : 0);
            check("R8", int'(dma_req), m_dma);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_evt(input int bits, input bit rd);
        evt_pulse = bits[N_EVT-1:0];
        stat_rd = rd;
        tick();
        evt_pulse = '0;
        stat_rd = 1'b0;
    endtask

    task automatic write_cfg(input int mask, input int thr);
        cfg_we = 1'b1;
        cfg_wdata = CFG_W'(thr * 256 + mask);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic set_count(input int c);
        fifo_count = CNT_W'(c);
        tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        check("R1", int'(irq_n), 1);
        check("R1", int'(dma_req), 0);
        check("R1", int'(stat_value), 0);
        rst_n = 1'b1;
        tick();

        // R2 / R4: event while masked latches but no interrupt
        pulse_evt(8'h08, 0);
        check("R2", int'(stat_value), 8'h08);
        check("R4", int'(irq_n), 1);
        tick();
        check("R2", int'(stat_value), 8'h08);

        // R7 / R3: enabling bit 3 asserts interrupt
        write_cfg(8'h08, 4);
        check("R7", int'(irq_n), 0);
        check("R3", int'(irq_n), 0);

        // R4: masked bit 0 alongside adds nothing after clearing bit 3
        pulse_evt(8'h01, 1);
        check("R4", int'(irq_n), 1);
        check("R6", int'(stat_value), 8'h01);

        // R5 / R10: read shows pending, then clears
        pulse_evt(8'h08, 0);
        check("R3", int'(irq_n), 0);
        stat_rd = 1'b1;
        #1;
        check("R5", int'(stat_value), 8'h09);
        tick();
        stat_rd = 1'b0;
        check("R5", int'(stat_value), 0);
        check("R10", int'(irq_n), 1);

        // R6: event coincident with read survives
        pulse_evt(8'h20, 0);
        pulse_evt(8'h08, 1);
        check("R6", int'(stat_value), 8'h08);
        check("R6", int'(irq_n), 0);
        pulse_evt(0, 1);

        // R8: DMA rises at threshold and holds
        for (int c = 1; c <= 3; c++) begin
            set_count(c);
            check("R8", int'(dma_req), 0);
        end
        set_count(4);
        check("R8", int'(dma_req), 1);
        set_count(2);
        check("R8", int'(dma_req), 1);
        set_count(6);
        check("R8", int'(dma_req), 1);
        // R9: empty clears
        set_count(0);
        check("R9", int'(dma_req), 0);
        set_count(1);
        check("R9", int'(dma_req), 0);

        // R9: threshold 0 never raises
        write_cfg(8'hFF, 0);
        set_count(0);
        check("R9", int'(dma_req), 0);
        set_count(3);
        check("R9", int'(dma_req), 0);
        set_count(0);

        // Random phase, model compared every cycle
        for (int i = 0; i < 2000; i++) begin
            int r;
            int c;
            r = int'($urandom % 16);
            evt_pulse = ($urandom % 4 == 0) ? N_EVT'($urandom) : '0;
            stat_rd = (r == 0);
            cfg_we = (r == 1);
            cfg_wdata = CFG_W'($urandom % 256 + ($urandom % 8) * 256);
            c = int'(fifo_count);
            if (r > 9 && c < 20) c++;
            else if (r > 5 && r < 10 && c > 0) c--;
            fifo_count = CNT_W'(c);
            tick();
        end
        evt_pulse = '0; stat_rd = 1'b0; cfg_we = 1'b0;
        tick();
        finish_run();
    end

endmodule